// File: doc/BRIEF.md
# Programming-Mode Address Pointer

This block holds the 14-bit location pointer that a flash microcontroller uses while it is in serial programming mode. The pointer selects which word of the memory arrays is read or written. The pointer space has two halves. The lower half, 0x0000 to 0x1FFF, is user program space. The upper half, 0x2000 to 0x3FFF, is configuration space. The pointer advances by one on an increment strobe. A load-configuration strobe moves it to the base of configuration space. A synchronous reset, issued when the part re-enters programming mode, returns it to zero.

The two halves wrap in different ways. In user space the pointer runs straight from 0x1FFF into 0x2000. Once the top bit is set, the pointer cycles inside configuration space and comes back to 0x2000 after 0x3FFF, so it never returns to 0x0000. Only a reset leaves configuration space.

The pointer is decoded into several outputs. Only 4K user words and a 32-word configuration row exist physically, so the block produces a 12-bit physical user-array address. It also produces three region flags, a location-class code and an 8-bit index into the 256-byte data memory. The memory arrays, the command decoder and the programming timing belong to neighbouring blocks.

Top module: `pac_prog_addr_ctr`

## Requirements
- R1: A synchronous reset sets the pointer to 0x0000. After reset all three region flags are low and the location class is 0.
- R2: A load-configuration strobe sets the pointer to 0x2000 from any value. When it comes in the same cycle as an increment strobe, the load wins.
- R3: While bit 13 of the pointer is clear, an increment adds one. From 0x1FFF the pointer moves to 0x2000.
- R4: While bit 13 is set, an increment adds one, and 0x3FFF wraps to 0x2000. Bit 13 stays set until a reset, whatever strobes arrive.
- R5: With neither strobe asserted, the pointer holds its value.
- R6: The physical user address is the pointer's low 12 bits for every pointer value. User addresses 0x1000–0x1FFF alias onto 0x000–0xFFF, and configuration addresses above 0x201F also reach the user array.
- R7: `cfg_row_o` is high exactly when the pointer is in 0x2000–0x201F, the physically present configuration row.
- R8: `cfg_avail_o` is high exactly when the pointer is in 0x2000–0x2008.
- R9: `data_idx_o` equals the pointer's low 8 bits.
- R10: `loc_kind_o` encodes the location class as follows: 0 for user space; 1 for ID words 0x2000–0x2003; 2 for reserved row words 0x2004, 0x2005 and 0x2009–0x201F; 3 for the device ID at 0x2006; 4 for configuration word 1 at 0x2007; 5 for configuration word 2 at 0x2008; 6 for configuration addresses above 0x201F.
- R11: `in_cfg_o` is high exactly when the pointer is at 0x2000 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (programming-mode re-entry) |
| inc_i | input | 1 | Single-cycle increment strobe |
| load_cfg_i | input | 1 | Single-cycle strobe that jumps to configuration base |
| ptr_o | output | 14 | Full pointer value |
| user_addr_o | output | 12 | Physical user-array word address |
| in_cfg_o | output | 1 | Pointer is in configuration space |
| cfg_row_o | output | 1 | Pointer is in the physical configuration row |
| cfg_avail_o | output | 1 | Pointer is on a usable configuration location |
| data_idx_o | output | 8 | Data-memory byte index |
| loc_kind_o | output | 3 | Location class code |

## Verification
The assertions check several properties on every cycle. They check the step, hold, load-priority and sticky-top-bit behaviour of the pointer. They check the wrap from 0x3FFF back to 0x2000. They also check that the usable-configuration flag implies the row flag, and that the user class appears only outside configuration space. The decode values, such as the class at each configuration location, the aliasing of the physical address and the data index, come only from the bench's sweep. That sweep runs the pointer through every value of both halves and compares each output with figures it computes from the address arithmetic. Return to zero by reset, and the load-over-increment collision, are shown by directed scenarios.

// File: rtl/pac_pkg.sv
package pac_pkg;

    localparam int ADDR_W      = 14;
    localparam int ROW_W       = 5;
    localparam int USER_PHYS_W = 12;
    localparam int DIDX_W      = 8;
    localparam int HI_BIT      = ADDR_W - 1;

    typedef logic [ADDR_W-1:0] ptr_t;

    localparam ptr_t PTR_ZERO = '0;
    localparam ptr_t CFG_BASE = ptr_t'(1) << HI_BIT;

    localparam logic [ROW_W-1:0] ID_LAST    = ROW_W'(3);
    localparam logic [ROW_W-1:0] DEVID_OFS  = ROW_W'(6);
    localparam logic [ROW_W-1:0] CFGW1_OFS  = ROW_W'(7);
    localparam logic [ROW_W-1:0] CFGW2_OFS  = ROW_W'(8);
    localparam logic [ROW_W-1:0] AVAIL_LAST = CFGW2_OFS;

    typedef enum logic [2:0] {
        LOC_USER   = 3'd0,
        LOC_ID     = 3'd1,
        LOC_RSVD   = 3'd2,
        LOC_DEVID  = 3'd3,
        LOC_CFGW1  = 3'd4,
        LOC_CFGW2  = 3'd5,
        LOC_BEYOND = 3'd6
    } loc_kind_e;

    typedef struct packed {
        logic load;
        logic inc;
    } strobe_t;

    typedef struct packed {
        logic      in_cfg;
        logic      row_hit;
        logic      avail;
        loc_kind_e kind;
    } region_t;

    // Next pointer: load has priority; top half wraps inside itself.
    function automatic ptr_t next_ptr(ptr_t p, strobe_t s);
        ptr_t n;
        n = p;
        if (s.load) begin
            n = CFG_BASE;
        end else if (s.inc) begin
            if (p[HI_BIT]) begin
                n = {1'b1, p[HI_BIT-1:0] + 1'b1};
            end else begin
                n = p + 1'b1;
            end
        end
        return n;
    endfunction

    function automatic logic in_row(ptr_t p);
        return p[HI_BIT] && (p[HI_BIT-1:ROW_W] == '0);
    endfunction

    function automatic loc_kind_e classify(ptr_t p);
        loc_kind_e k;
        logic [ROW_W-1:0] ofs;
        ofs = p[ROW_W-1:0];
        if (!p[HI_BIT]) begin
            k = LOC_USER;
        end else if (!in_row(p)) begin
            k = LOC_BEYOND;
        end else if (ofs <= ID_LAST) begin
            k = LOC_ID;
        end else if (ofs == DEVID_OFS) begin
            k = LOC_DEVID;
        end else if (ofs == CFGW1_OFS) begin
            k = LOC_CFGW1;
        end else if (ofs == CFGW2_OFS) begin
            k = LOC_CFGW2;
        end else begin
            k = LOC_RSVD;
        end
        return k;
    endfunction

endpackage

// File: rtl/pac_pointer.sv
module pac_pointer
    import pac_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t strobe,
    output ptr_t    ptr
);

    ptr_t ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= PTR_ZERO;
        end else begin
            ptr_q <= next_ptr(ptr_q, strobe);
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/pac_region_decode.sv
module pac_region_decode
    import pac_pkg::*;
(
    input  ptr_t    ptr,
    output region_t region
);

    always_comb begin
        region.in_cfg  = ptr[HI_BIT];
        region.row_hit = in_row(ptr);
        region.avail   = in_row(ptr) && (ptr[ROW_W-1:0] <= AVAIL_LAST);
        region.kind    = classify(ptr);
    end

endmodule

// File: rtl/pac_phys_map.sv
module pac_phys_map
    import pac_pkg::*;
#(
    parameter int PHYS_W = USER_PHYS_W,
    parameter int IDX_W  = DIDX_W
) (
    input  ptr_t              ptr,
    output logic [PHYS_W-1:0] user_addr,
    output logic [IDX_W-1:0]  data_idx
);

    generate
        if (PHYS_W < ADDR_W) begin : g_alias
            assign user_addr = ptr[PHYS_W-1:0];
        end else begin : g_full
            assign user_addr = PHYS_W'(ptr);
        end
    endgenerate

    assign data_idx = ptr[IDX_W-1:0];

endmodule

// File: rtl/pac_prog_addr_ctr.sv
module pac_prog_addr_ctr
    import pac_pkg::*;
#(
    parameter int PHYS_W = USER_PHYS_W,
    parameter int IDX_W  = DIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_i,
    input  logic              load_cfg_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [PHYS_W-1:0] user_addr_o,
    output logic              in_cfg_o,
    output logic              cfg_row_o,
    output logic              cfg_avail_o,
    output logic [IDX_W-1:0]  data_idx_o,
    output logic [2:0]        loc_kind_o
);

    strobe_t strobe;
    ptr_t    ptr;
    region_t region;

    assign strobe.load = load_cfg_i;
    assign strobe.inc  = inc_i;

    pac_pointer u_pointer (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .ptr    (ptr)
    );

    pac_region_decode u_decode (
        .ptr    (ptr),
        .region (region)
    );

    pac_phys_map #(
        .PHYS_W (PHYS_W),
        .IDX_W  (IDX_W)
    ) u_map (
        .ptr       (ptr),
        .user_addr (user_addr_o),
        .data_idx  (data_idx_o)
    );

    assign ptr_o       = ptr;
    assign in_cfg_o    = region.in_cfg;
    assign cfg_row_o   = region.row_hit;
    assign cfg_avail_o = region.avail;
    assign loc_kind_o  = region.kind;

endmodule

// File: rtl/pac_prog_addr_ctr_chk.sv
module pac_prog_addr_ctr_chk
    import pac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              inc_i,
    input logic              load_cfg_i,
    input logic [ADDR_W-1:0] ptr_o,
    input logic              in_cfg_o,
    input logic              cfg_row_o,
    input logic              cfg_avail_o,
    input logic [2:0]        loc_kind_o
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    AST_LOAD_TO_BASE: assert property (@(posedge clk) disable iff (rst)
        load_cfg_i |=> ptr_o == CFG_BASE);                         // R2

    AST_USER_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !load_cfg_i && !ptr_o[HI_BIT]) |=>
            ptr_o == $past(ptr_o) + 1'b1);                         // R3

    AST_CFG_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !load_cfg_i && ptr_o[HI_BIT] && ptr_o != TOP_ADDR) |=>
            ptr_o == $past(ptr_o) + 1'b1);                         // R4

    AST_CFG_WRAP: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !load_cfg_i && ptr_o == TOP_ADDR) |=> ptr_o == CFG_BASE); // R4

    AST_CFG_STICKY: assert property (@(posedge clk) disable iff (rst)
        ptr_o[HI_BIT] |=> ptr_o[HI_BIT]);                          // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!inc_i && !load_cfg_i) |=> $stable(ptr_o));               // R5

    AST_AVAIL_IN_ROW: assert property (@(posedge clk) disable iff (rst)
        cfg_avail_o |-> (cfg_row_o && in_cfg_o));                  // R8

    AST_ROW_IN_CFG: assert property (@(posedge clk) disable iff (rst)
        cfg_row_o |-> in_cfg_o);                                   // R7

    AST_USER_KIND: assert property (@(posedge clk) disable iff (rst)
        (loc_kind_o == 3'd0) |-> !in_cfg_o);                       // R10

endmodule

bind pac_prog_addr_ctr pac_prog_addr_ctr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .inc_i       (inc_i),
    .load_cfg_i  (load_cfg_i),
    .ptr_o       (ptr_o),
    .in_cfg_o    (in_cfg_o),
    .cfg_row_o   (cfg_row_o),
    .cfg_avail_o (cfg_avail_o),
    .loc_kind_o  (loc_kind_o)
);

// File: tb/test_pac_prog_addr_ctr.sv
`timescale 1ns/100ps
module test_pac_prog_addr_ctr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inc_i = 1'b0;
    logic        load_cfg_i = 1'b0;
    logic [13:0] ptr_o;
    logic [11:0] user_addr_o;
    logic        in_cfg_o;
    logic        cfg_row_o;
    logic        cfg_avail_o;
    logic [7:0]  data_idx_o;
    logic [2:0]  loc_kind_o;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_ptr = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pac_prog_addr_ctr i_pac_prog_addr_ctr (
        .clk         (clk),
        .rst         (rst),
        .inc_i       (inc_i),
        .load_cfg_i  (load_cfg_i),
        .ptr_o       (ptr_o),
        .user_addr_o (user_addr_o),
        .in_cfg_o    (in_cfg_o),
        .cfg_row_o   (cfg_row_o),
        .cfg_avail_o (cfg_avail_o),
        .data_idx_o  (data_idx_o),
        .loc_kind_o  (loc_kind_o)
    );

    function automatic int kind_of(int a);
        if (a < 'h2000)                    return 0;
        if (a > 'h201F)                    return 6;
        if (a <= 'h2003)                   return 1;
        if (a == 'h2006)                   return 3;
        if (a == 'h2007)                   return 4;
        if (a == 'h2008)                   return 5;
        return 2;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at ptr model 0x%0h",
                     tag, what, act, exp, exp_ptr);
        end
    endtask

    task automatic check_all(string tag);
        cmp(tag, "ptr", int'(ptr_o), exp_ptr);
        cmp("R6", "user_addr", int'(user_addr_o), exp_ptr % 4096);
        cmp("R11", "in_cfg", int'(in_cfg_o), (exp_ptr >= 'h2000) ? 1 : 0);
        cmp("R7", "cfg_row", int'(cfg_row_o),
            (exp_ptr >= 'h2000 && exp_ptr <= 'h201F) ? 1 : 0);
        cmp("R8", "cfg_avail", int'(cfg_avail_o),
            (exp_ptr >= 'h2000 && exp_ptr <= 'h2008) ? 1 : 0);
        cmp("R9", "data_idx", int'(data_idx_o), exp_ptr % 256);
        cmp("R10", "loc_kind", int'(loc_kind_o), kind_of(exp_ptr));
    endtask

    // One clock: drive at negedge, sample 1 ns after the rising edge.
    task automatic step(bit r, bit inc, bit ld, string tag);
        @(negedge clk);
        rst = r; inc_i = inc; load_cfg_i = ld;
        @(posedge clk);
        if (r)            exp_ptr = 0;
        else if (ld)      exp_ptr = 'h2000;
        else if (inc) begin
            if (exp_ptr >= 'h2000) exp_ptr = (exp_ptr == 'h3FFF) ? 'h2000 : exp_ptr + 1;
            else                   exp_ptr = exp_ptr + 1;
        end
        #1;
        check_all(tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b1, 1'b1, "R1");

        // R3, R4: sweep all of user space, then around configuration space twice
        for (int i = 0; i < 'h2000; i++) step(1'b0, 1'b1, 1'b0, "R3");
        for (int i = 0; i < 'h4010; i++) step(1'b0, 1'b1, 1'b0, "R4");

        // R5: hold with no strobe
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, "R5");

        // R4: only reset leaves configuration space
        step(1'b1, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b0, "R5");

        // R2: load from user space, collided with increment
        for (int i = 0; i < 'h123; i++) step(1'b0, 1'b1, 1'b0, "R3");
        step(1'b0, 1'b1, 1'b1, "R2");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b1, "R2");
        step(1'b0, 1'b0, 1'b1, "R2");

        // R3: alias range 0x1000-0x1FFF after a fresh reset, then load
        step(1'b1, 1'b0, 1'b0, "R1");
        for (int i = 0; i < 'h1005; i++) step(1'b0, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b1, "R2");
        step(1'b1, 1'b1, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b0, "R5");

        finish_run();
    end

endmodule